// File: doc/BRIEF.md
# DMA Audio Frame Playback Engine

This block plays 8-bit signed audio samples from memory. Software loads a frame as a start byte address and an exclusive end byte address, selects stereo or mono and one of four sample rates, and then starts playback once or in repeat mode. The engine reads memory one 16-bit word at a time through a request/acknowledge port and places the words in a small FIFO. A rate tick generator moves samples from the FIFO to the left and right outputs.

The start and end address registers are double-buffered. Software writes go into holding copies, and the engine copies them into its working set only while it is idle or when a frame ends. Software can therefore queue the next frame while the current one is still playing, and repeated or chained frames join without a gap. A "playback active" output drops for one cycle at each frame wrap, so an external event counter can count played frames. A second status output is that signal XORed with a monitor-detect input.

Register map (`reg_addr`):
- 0: control
- 1: start holding register
- 2: end holding register
- 3: current fetch address (read only)
- 4: mode

Top module: `dma_audio_engine`

## Requirements
- R1: Control bit 0 enables playback and bit 1 selects repeat. Writing 01 plays one frame and writing 11 repeats forever. The control register reads back 11 or 01 while running, and 00 after reset or once a single-shot frame has finished fetching.
- R2: Words are fetched at byte addresses start, start+2, and so on up to end-2. The end address is exclusive, and bit 0 of written start and end values is forced to 0.
- R3: A fetch request is raised while running, the fetch address differs from the end address, and the 4-word FIFO has a free entry. A word is taken in a cycle where both `mem_req` and `mem_ack` are high.
- R4: In stereo (mode bit 7 = 0), each rate tick pops one word. The high byte goes to `sample_l` and the low byte goes to `sample_r`.
- R5: In mono (mode bit 7 = 1), the first tick places the high byte of the head word on both channels and the second tick places the low byte on both channels. The word is popped on the second tick.
- R6: Mode bits [1:0] select the rate. The tick period is BASE_DIV × 8, × 4, × 2 or × 1 clocks for the codes 00, 01, 10 and 11. The reset mode is 0 (stereo, slowest rate). `sample_stb` pulses in the cycle the outputs take a new value.
- R7: Writes to the start and end registers reach the working frame only while idle or at a frame end. A frame in progress keeps its addresses.
- R8: `play_active` is high while running with fetches remaining in the frame. It is low in the cycle the fetch address reaches the end. In repeat mode it returns high in the next cycle; after a single-shot frame it stays low.
- R9: `play_status_x` equals `play_active` XOR `mon_detect`.
- R10: A rate tick with an empty FIFO sets both outputs to 0, the midpoint.
- R11: Writing a control value with bit 0 clear stops fetching at the next edge, empties the FIFO and clears `play_active`.
- R12: Register 3 reads back the current fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for writes and reads |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data for `reg_addr` |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_ack | input | 1 | Memory accepts the request; data is valid this cycle |
| mem_rdata | input | 16 | Fetched word |
| mon_detect | input | 1 | External monitor-detect level |
| sample_l | output | 8 | Left sample, signed |
| sample_r | output | 8 | Right sample, signed |
| sample_stb | output | 1 | New sample pair strobe |
| play_active | output | 1 | Playback active |
| play_status_x | output | 1 | `play_active` XOR `mon_detect` |

## Verification
A wrong fetch pointer or working end address shows up on `mem_addr` in the very next request, and it changes how many words the frame fetches. A missing wrap reload or an early hold copy shows up within one frame, as a missing `play_active` pulse or as a fetch outside the expected frame. FIFO or mono-phase faults show up at the next rate tick on `sample_l` and `sample_r`. The reference model compares every port on every clock, so most faults surface within one tick period.

// File: rtl/dma_audio_pkg.sv
package dma_audio_pkg;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_START = 3'd1;
  localparam logic [2:0] RA_END   = 3'd2;
  localparam logic [2:0] RA_CUR   = 3'd3;
  localparam logic [2:0] RA_MODE  = 3'd4;

  typedef struct packed {
    logic [7:0] left;
    logic [7:0] right;
  } stereo_t;

  // clocks between rate ticks: fastest code 11 uses base, each step down doubles
  function automatic int unsigned tick_period(int unsigned base, logic [1:0] rate);
    return base << (3 - int'(rate));
  endfunction

  // sample pair produced from a FIFO word for the current mono phase
  function automatic stereo_t split_word(logic [15:0] w, logic mono, logic second);
    stereo_t s;
    if (!mono)        s = '{left: w[15:8], right: w[7:0]};
    else if (!second) s = '{left: w[15:8], right: w[15:8]};
    else              s = '{left: w[7:0],  right: w[7:0]};
    return s;
  endfunction

endpackage

// File: rtl/audio_rate_gen.sv
module audio_rate_gen #(
  parameter int unsigned BASE_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate,
  output logic       tick
);
  import dma_audio_pkg::*;

  localparam int CNT_W = $clog2(BASE_DIV * 8);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(tick_period(BASE_DIV, rate) - 1);
  assign tick  = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R6: every period is at least two clocks, so ticks never come back to back
  assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/audio_word_fifo.sv
module audio_word_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign head    = store[rd_ptr];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !flush) store[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3: the fetch side must never offer a word when all entries are taken
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R10: the output side must not pop from an empty FIFO
  assert_no_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/audio_sample_out.sv
module audio_sample_out (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        mono,
  input  logic        flush,
  input  logic        fifo_empty,
  input  logic [15:0] head,
  output logic        pop,
  output logic [7:0]  left,
  output logic [7:0]  right,
  output logic        strobe
);
  import dma_audio_pkg::*;

  logic    half;
  stereo_t pair;

  assign pair = split_word(head, mono, half);
  assign pop  = tick && !fifo_empty && (!mono || half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half   <= 1'b0;
      left   <= '0;
      right  <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= tick;
      if (flush || !mono)           half <= 1'b0;
      else if (tick && !fifo_empty) half <= ~half;
      if (tick) begin
        if (fifo_empty) begin
          left  <= '0;
          right <= '0;
        end else begin
          left  <= pair.left;
          right <= pair.right;
        end
      end
    end
  end

  // R5: a first mono tick on a word moves on to the second byte
  assert_mono_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mono && !half && !fifo_empty && !flush) |=> half);

endmodule

// File: rtl/dma_audio_engine.sv
module dma_audio_engine #(
  parameter int          ADDR_W     = 24,
  parameter int          FIFO_DEPTH = 4,
  parameter int unsigned BASE_DIV   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata,
  input  logic              mon_detect,
  output logic [7:0]        sample_l,
  output logic [7:0]        sample_r,
  output logic              sample_stb,
  output logic              play_active,
  output logic              play_status_x
);
  import dma_audio_pkg::*;

  logic [ADDR_W-1:0] hold_start, hold_end, fetch_addr, work_end;
  logic              run, rpt, mono;
  logic [1:0]        rate;
  logic              wr_ctrl, stop_wr, go_wr, end_evt, xfer;
  logic              tick, fifo_pop, fifo_empty, fifo_full;
  logic [15:0]       fifo_head;

  // named events for the checks
  assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign stop_wr = wr_ctrl && !reg_wdata[0];
  assign go_wr   = wr_ctrl && reg_wdata[0];
  assign end_evt = run && (fetch_addr == work_end);
  assign mem_req = run && !end_evt && !fifo_full;
  assign xfer    = mem_req && mem_ack;
  assign mem_addr = fetch_addr;

  assign play_active   = run && !end_evt;
  assign play_status_x = play_active ^ mon_detect;

  // registers written by software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_start <= '0;
      hold_end   <= '0;
      mono       <= 1'b0;
      rate       <= 2'b00;
    end else if (reg_we) begin
      case (reg_addr)
        RA_START: hold_start <= {reg_wdata[ADDR_W-1:1], 1'b0};
        RA_END:   hold_end   <= {reg_wdata[ADDR_W-1:1], 1'b0};
        RA_MODE: begin
          mono <= reg_wdata[7];
          rate <= reg_wdata[1:0];
        end
        default: ;
      endcase
    end
  end

  // working frame: follows the holding pair while idle, reloads at frame end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_addr <= '0;
      work_end   <= '0;
    end else if (!run || stop_wr || end_evt) begin
      fetch_addr <= hold_start;
      work_end   <= hold_end;
    end else if (xfer) begin
      fetch_addr <= fetch_addr + ADDR_W'(2);
    end
  end

  // playback state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      rpt <= 1'b0;
    end else if (stop_wr) begin
      run <= 1'b0;
    end else if (!run) begin
      if (go_wr) begin
        run <= 1'b1;
        rpt <= reg_wdata[1];
      end
    end else begin
      if (go_wr) rpt <= reg_wdata[1];
      if (end_evt && !rpt) run <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL:  reg_rdata = {{(ADDR_W-2){1'b0}}, (run ? {rpt, 1'b1} : 2'b00)};
      RA_START: reg_rdata = hold_start;
      RA_END:   reg_rdata = hold_end;
      RA_CUR:   reg_rdata = fetch_addr;
      RA_MODE:  reg_rdata = {{(ADDR_W-8){1'b0}}, mono, 5'b0, rate};
      default:  reg_rdata = '0;
    endcase
  end

  audio_rate_gen #(.BASE_DIV(BASE_DIV)) u_rate (
    .clk(clk), .rst_n(rst_n), .rate(rate), .tick(tick)
  );

  audio_word_fifo #(.DEPTH(FIFO_DEPTH), .W(16)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(stop_wr), .push(xfer), .wdata(mem_rdata),
    .pop(fifo_pop), .head(fifo_head), .empty(fifo_empty), .full(fifo_full)
  );

  audio_sample_out u_out (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mono(mono), .flush(stop_wr),
    .fifo_empty(fifo_empty), .head(fifo_head), .pop(fifo_pop),
    .left(sample_l), .right(sample_r), .strobe(sample_stb)
  );

  // R2: each accepted word advances the fetch address by one word
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !stop_wr) |=> (fetch_addr == $past(fetch_addr) + ADDR_W'(2)));
  // R1: a single-shot frame ends playback once its last word is fetched
  assert_once_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && !rpt && !stop_wr) |=> !run);
  // R7: the working end address holds still inside a frame
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !end_evt && !stop_wr) |=> $stable(work_end));
  // R8: a repeat wrap into a non-empty frame raises active again
  assert_wrap_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && rpt && !stop_wr && (hold_start != hold_end)) |=> play_active);
  // R11: stopping empties the FIFO and leaves the engine idle
  assert_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> (!run && fifo_empty));

endmodule

// File: tb/sim_dma_audio_engine.sv
module sim_dma_audio_engine;
  localparam int          AW    = 24;
  localparam int          DEPTH = 4;
  localparam int unsigned BASE  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = 3'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 1'b1;
  logic [15:0]   mem_rdata;
  logic          mon_detect = 1'b0;
  logic [7:0]    sample_l, sample_r;
  logic          sample_stb, play_active, play_status_x;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ack_mode = 0;
  int xfer_cnt = 0;
  int fall_cnt = 0;
  bit prev_act = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] word_at(logic [AW-1:0] a);
    return {a[8:1] ^ 8'hA5, a[8:1] + 8'h3C};
  endfunction

  assign mem_rdata = word_at(mem_addr);

  dma_audio_engine #(.ADDR_W(AW), .FIFO_DEPTH(DEPTH), .BASE_DIV(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mon_detect(mon_detect), .sample_l(sample_l), .sample_r(sample_r),
    .sample_stb(sample_stb), .play_active(play_active),
    .play_status_x(play_status_x)
  );

  // ---------------- behavioural reference model ----------------
  bit            m_run, m_rpt, m_mono, m_half, m_stb;
  logic [1:0]    m_rate;
  logic [AW-1:0] m_hs, m_he, m_fa, m_we;
  logic [7:0]    m_l, m_r;
  logic [15:0]   q[$];
  int            m_cnt;

  function automatic logic [AW-1:0] model_read(logic [2:0] a);
    case (a)
      3'd0: return m_run ? AW'({m_rpt, 1'b1}) : '0;
      3'd1: return m_hs;
      3'd2: return m_he;
      3'd3: return m_fa;
      3'd4: return AW'({m_mono, 5'b0, m_rate});
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_rpt = 0; m_mono = 0; m_half = 0; m_stb = 0; m_rate = 0;
      m_hs = '0; m_he = '0; m_fa = '0; m_we = '0; m_l = 0; m_r = 0;
      q.delete(); m_cnt = 0;
    end else begin
      automatic bit endv = m_run && (m_fa == m_we);
      automatic bit req  = m_run && !endv && (q.size() < DEPTH);
      automatic bit xf   = req && mem_ack;
      automatic int per  = int'(BASE) << (3 - int'(m_rate));
      automatic bit tk   = (m_cnt >= per - 1);
      automatic bit wc   = reg_we && (reg_addr == 3'd0);
      automatic bit stop = wc && !reg_wdata[0];
      automatic bit go   = wc && reg_wdata[0];
      automatic bit emp  = (q.size() == 0);
      automatic logic [15:0] hd = emp ? 16'h0 : q[0];
      automatic logic [15:0] wd = word_at(m_fa);
      automatic bit pop  = tk && !emp && (!m_mono || m_half);
      m_stb = tk;
      if (tk) begin
        if (emp)          begin m_l = 0;          m_r = 0;          end
        else if (!m_mono) begin m_l = hd[15:8];   m_r = hd[7:0];    end
        else if (!m_half) begin m_l = hd[15:8];   m_r = hd[15:8];   end
        else              begin m_l = hd[7:0];    m_r = hd[7:0];    end
      end
      if (stop || !m_mono)  m_half = 0;
      else if (tk && !emp)  m_half = !m_half;
      if (stop) q.delete();
      else begin
        if (pop) void'(q.pop_front());
        if (xf)  q.push_back(wd);
      end
      if (!m_run || stop || endv) begin m_fa = m_hs; m_we = m_he; end
      else if (xf) m_fa = m_fa + AW'(2);
      if (stop) m_run = 0;
      else if (!m_run) begin
        if (go) begin m_run = 1; m_rpt = reg_wdata[1]; end
      end else begin
        automatic bit old_rpt = m_rpt;
        if (go) m_rpt = reg_wdata[1];
        if (endv && !old_rpt) m_run = 0;
      end
      m_cnt = tk ? 0 : m_cnt + 1;
      if (reg_we && reg_addr == 3'd1) m_hs = {reg_wdata[AW-1:1], 1'b0};
      if (reg_we && reg_addr == 3'd2) m_he = {reg_wdata[AW-1:1], 1'b0};
      if (reg_we && reg_addr == 3'd4) begin m_mono = reg_wdata[7]; m_rate = reg_wdata[1:0]; end
    end
  end

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit e  = m_run && (m_fa == m_we);
      automatic bit rq = m_run && !e && (q.size() < DEPTH);
      automatic bit ac = m_run && !e;
      cmp(32'(mem_req), 32'(rq), "R3 mem_req");
      if (rq) cmp(32'(mem_addr), 32'(m_fa), "R2 mem_addr");
      cmp(32'(play_active), 32'(ac), "R8 play_active");
      cmp(32'(play_status_x), 32'(ac ^ mon_detect), "R9 play_status_x");
      cmp(32'(sample_l), 32'(m_l), m_mono ? "R5 sample_l" : "R4 sample_l");
      cmp(32'(sample_r), 32'(m_r), m_mono ? "R5 sample_r" : "R4 sample_r");
      cmp(32'(sample_stb), 32'(m_stb), "R6 sample_stb");
      cmp(32'(reg_rdata), 32'(model_read(reg_addr)), "R12 reg_rdata");
      if (mem_req && mem_ack) xfer_cnt++;
      if (prev_act && !play_active) fall_cnt++;
      prev_act = play_active;
    end
  end

  // background input drivers: ack pattern and monitor-detect toggling
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      mem_ack    = (ack_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
      mon_detect = ((cyc / 7) % 2) == 1;
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [AW-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [AW-1:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [AW-1:0] v;
    int gap;
    step(3);
    rst_n = 1'b1;
    step();
    // reset state
    rd(3'd0, v); chk(v == 0, "R1 ctrl after reset", v, 0);
    rd(3'd4, v); chk(v == 0, "R6 mode after reset", v, 0);
    chk(play_active == 0, "R8 active after reset", 32'(play_active), 0);
    chk(sample_l == 0 && sample_r == 0, "R10 samples after reset", 32'({sample_l, sample_r}), 0);

    // odd address forced to a word boundary
    wr(3'd1, 24'h000101);
    rd(3'd1, v); chk(v == 24'h000100, "R2 start alignment", v, 24'h100);

    // stereo, fastest rate, single shot, 8 words
    wr(3'd4, 24'h000003);
    wr(3'd2, 24'h000110);
    xfer_cnt = 0; fall_cnt = 0;
    wr(3'd0, 24'h000001);
    rd(3'd0, v); chk(v == 1, "R1 ctrl running once", v, 1);
    step(2);
    rd(3'd3, v); chk(v == mem_addr, "R12 current address", v, 32'(mem_addr));
    step(80);
    chk(xfer_cnt == 8, "R2 stereo word count", 32'(xfer_cnt), 8);
    chk(fall_cnt == 1, "R8 single-shot falls", 32'(fall_cnt), 1);
    rd(3'd0, v); chk(v == 0, "R1 ctrl after single shot", v, 0);
    chk(sample_l == 0 && sample_r == 0, "R10 underrun midpoint", 32'({sample_l, sample_r}), 0);

    // mono repeat, next frame queued while the first one plays
    wr(3'd4, 24'h000082);
    wr(3'd1, 24'h000200);
    wr(3'd2, 24'h000208);
    xfer_cnt = 0; fall_cnt = 0;
    wr(3'd0, 24'h000003);
    wr(3'd1, 24'h000300);
    wr(3'd2, 24'h000304);
    rd(3'd3, v); chk(v >= 24'h200 && v <= 24'h208, "R7 frame kept in progress", v, 24'h200);
    step(300);
    chk(fall_cnt >= 3, "R8 repeat falls", 32'(fall_cnt), 3);
    rd(3'd3, v); chk(v >= 24'h300 && v <= 24'h304, "R7 chained frame", v, 24'h300);
    wr(3'd0, 24'h000001);
    step(120);
    rd(3'd0, v); chk(v == 0, "R1 ctrl after switch to once", v, 0);

    // stop in the middle of a repeating stereo frame with a slow memory
    ack_mode = 1;
    wr(3'd4, 24'h000003);
    wr(3'd1, 24'h000400);
    wr(3'd2, 24'h000440);
    wr(3'd0, 24'h000003);
    step(20);
    wr(3'd0, 24'h000000);
    chk(play_active == 0, "R11 active after stop", 32'(play_active), 0);
    chk(mem_req == 0, "R11 request after stop", 32'(mem_req), 0);
    step(12);
    chk(sample_l == 0 && sample_r == 0, "R11 flushed output", 32'({sample_l, sample_r}), 0);
    ack_mode = 0;

    // slowest rate tick spacing
    wr(3'd4, 24'h000000);
    while (!sample_stb) step();
    gap = 0;
    do begin step(); gap++; end while (!sample_stb);
    chk(gap == int'(BASE) * 8, "R6 slow rate period", 32'(gap), 32'(BASE * 8));

    step(4);
    done = 1;
    finish_run();
  end

endmodule